// File: doc/BRIEF.md
# Transfer Group Interrupt Flag Unit

This block keeps the event flags of one data-transfer group inside a digital I/O acquisition engine and turns them into an interrupt request. The FIFO, the DMA engine and the handshake timer sit outside the block. They report to it through single-cycle event pulses and one live FIFO-not-empty level. Software reaches the block through a small 8-bit register port. Over that port it reads the flags, masks them, chooses how the interrupt pin is driven, clears flags one at a time, and fires one-cycle reset strobes towards the DMA engine and the FIFO.

Two clear registers remove flags, and the clear bits do not sit at the same positions as the flags they remove. The count-expired flag has its own clear register. A flag whose event pulse lands in the same cycle as its clear stays set, so no event is lost.

Top module: `xfer_grp_irq_unit`

## Requirements
- R1: After reset, all latched flags, the enable register and the master control register are zero, `irq_req` is low and both reset strobes are low.
- R2: Reading address 0 returns the flag byte. Bit 0 is transfer-ready, bit 1 is count-expired, bit 5 is waited, bit 6 is primary terminal count and bit 7 is secondary terminal count. Bits 4:2 always read 0.
- R3: Transfer-ready (flag bit 0) follows the `ev_fifo_nonempty` input combinationally. It is not latched, and no clear bit affects it.
- R4: A one-cycle pulse on `ev_count_done`, `ev_wait_timeout`, `ev_ptc` or `ev_stc` sets flag bit 1, 5, 6 or 7 at that clock edge. The flag stays set until it is cleared.
- R5: A write to address 0 is the first clear register. A 1 at bit 3 clears waited, a 1 at bit 4 clears primary terminal count and a 1 at bit 5 clears secondary terminal count. Bits 2:0 have no effect, and this register never clears count-expired.
- R6: A write to address 1 with bit 0 set clears count-expired and nothing else. Address 1 reads as 0.
- R7: When a set pulse and a clear of the same flag arrive in the same cycle, the flag is set afterwards.
- R8: A write to address 0 with bit 6 set raises `dma_rst_pulse` for exactly the one cycle after the write edge. Bit 7 does the same for `fifo_rst_pulse`. The value 0xF8 clears waited and both terminal-count flags and raises both strobes.
- R9: Address 2 is the interrupt-enable register, laid out like the flag byte. Only bits 7:5 and 1:0 are stored, so it reads back as the written value AND 0xE3.
- R10: Address 3 is the master control register. Bits 2:0 are stored and read back. Bits 1:0 drive `irq_line_sel` and bit 2 drives `irq_open_drain`. Bits 7:3 read as 0.
- R11: `irq_req` is high exactly when (flags AND enable) is nonzero and the master control value is nonzero. Writing 0 to master control forces it low.
- R12: Address 4 is the summary status. Bit 0 is high when (flags AND enable) is nonzero, whatever the master control value. Bit 1 mirrors `irq_req`. Bits 7:2 read 0. Addresses 5 to 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register byte offset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ev_fifo_nonempty | input | 1 | Live FIFO-has-data level |
| ev_count_done | input | 1 | Transfer count expired pulse |
| ev_wait_timeout | input | 1 | Handshake wait timeout pulse |
| ev_ptc | input | 1 | Primary terminal count pulse |
| ev_stc | input | 1 | Secondary terminal count pulse |
| irq_req | output | 1 | Active-high interrupt request level |
| irq_line_sel | output | 2 | Selected interrupt line |
| irq_open_drain | output | 1 | Open-collector drive select |
| dma_rst_pulse | output | 1 | One-cycle DMA reset strobe |
| fifo_rst_pulse | output | 1 | One-cycle FIFO reset strobe |

## Verification
Each result has a fixed due point. Flags, enable, master control and clears take effect at the clock edge that samples the pulse or write, and both read data and `irq_req` are combinational from those registers, so they are due directly after that edge. The reset strobes pass through one register and are high only between the write edge and the next edge. Transfer-ready is combinational from its input and is due in the same cycle. The bench drives on falling edges and samples just after them, so every check falls inside the cycle in which its result must hold, and each strobe is also checked one cycle later to prove it has fallen.

// File: rtl/xgi_pkg.sv
// Package: shared widths, register offsets and bit positions of the
// transfer group interrupt flag unit.
// Assumes an 8-bit register port with byte offsets on a 3-bit address.
package xgi_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int MCTL_W = 3;

    // Register offsets
    localparam logic [ADDR_W-1:0] OFS_FLAG_CLRA = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_CLRB      = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_ENABLE    = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_MASTER    = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_SUMMARY   = 3'd4;

    // Flag positions, also used by the enable register
    localparam int FB_READY = 0;
    localparam int FB_CNT   = 1;
    localparam int FB_WAIT  = 5;
    localparam int FB_PTC   = 6;
    localparam int FB_STC   = 7;

    // Clear register bit positions
    localparam int CA_WAIT = 3;
    localparam int CA_PTC  = 4;
    localparam int CA_STC  = 5;
    localparam int CA_DMA  = 6;
    localparam int CA_FIFO = 7;
    localparam int CB_CNT  = 0;

    // Derived masks
    localparam logic [DATA_W-1:0] LATCH_MASK =
        DATA_W'((1 << FB_CNT) | (1 << FB_WAIT) | (1 << FB_PTC) | (1 << FB_STC));
    localparam logic [DATA_W-1:0] LIVE_MASK = DATA_W'(1 << FB_READY);
    localparam logic [DATA_W-1:0] IMPL_MASK = LATCH_MASK | LIVE_MASK;

    // Mapping of one clear bit to the flag it removes
    typedef struct packed {
        logic       in_b;  // 1: second clear register, 0: first
        logic [2:0] src;   // bit position in the clear register
        logic [2:0] dst;   // flag position
    } clr_map_t;

    localparam int NUM_CLR = 4;
endpackage

// File: rtl/xgi_reg_decode.sv
// Register write decoder.
// Turns port writes into a flag-positioned clear vector, stores the enable
// and master control registers and produces the registered reset strobes.
// Assumes that a write lasts one cycle and that offsets follow xgi_pkg.
module xgi_reg_decode
    import xgi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] clr_vec,
    output logic [DATA_W-1:0] en_q,
    output logic [MCTL_W-1:0] mctl_q,
    output logic              dma_rst_q,
    output logic              fifo_rst_q
);
    function automatic clr_map_t map_entry(input int k);
        clr_map_t m;
        case (k)
            0:       m = '{in_b: 1'b0, src: 3'(CA_WAIT), dst: 3'(FB_WAIT)};
            1:       m = '{in_b: 1'b0, src: 3'(CA_PTC),  dst: 3'(FB_PTC)};
            2:       m = '{in_b: 1'b0, src: 3'(CA_STC),  dst: 3'(FB_STC)};
            default: m = '{in_b: 1'b1, src: 3'(CB_CNT),  dst: 3'(FB_CNT)};
        endcase
        return m;
    endfunction

    logic wr_a, wr_b, wr_en, wr_mc;
    logic [NUM_CLR-1:0] clr_hit;

    // Select which register a write targets
    always_comb begin
        wr_a  = bus_wr && (bus_addr == OFS_FLAG_CLRA);
        wr_b  = bus_wr && (bus_addr == OFS_CLRB);
        wr_en = bus_wr && (bus_addr == OFS_ENABLE);
        wr_mc = bus_wr && (bus_addr == OFS_MASTER);
    end

    // One hit per clear mapping entry
    for (genvar k = 0; k < NUM_CLR; k++) begin : g_clr
        localparam clr_map_t M = map_entry(k);
        assign clr_hit[k] = (M.in_b ? wr_b : wr_a) && bus_wdata[M.src];
    end

    // Scatter the clear hits onto flag positions
    always_comb begin
        clr_vec = '0;
        for (int k = 0; k < NUM_CLR; k++) begin
            clr_vec[map_entry(k).dst] = clr_hit[k];
        end
    end

    // Enable register keeps only implemented flag positions
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= bus_wdata & IMPL_MASK;
    end

    // Master control register
    always_ff @(posedge clk) begin
        if (!rst_n)     mctl_q <= '0;
        else if (wr_mc) mctl_q <= bus_wdata[MCTL_W-1:0];
    end

    // One-cycle reset strobes after a first-clear write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_rst_q  <= 1'b0;
            fifo_rst_q <= 1'b0;
        end else begin
            dma_rst_q  <= wr_a && bus_wdata[CA_DMA];
            fifo_rst_q <= wr_a && bus_wdata[CA_FIFO];
        end
    end
endmodule

// File: rtl/xgi_flag_bank.sv
// Flag storage.
// Latched positions set on their pulse and hold until cleared, and a set wins
// over a clear in the same cycle. Live positions pass their level through.
// Assumes set, clear and live vectors all use flag positions.
module xgi_flag_bank
    import xgi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_vec,
    input  logic [DATA_W-1:0] clr_vec,
    input  logic [DATA_W-1:0] live_vec,
    output logic [DATA_W-1:0] flag_vec
);
    logic [DATA_W-1:0] latch_q;
    logic [DATA_W-1:0] latch_d;

    // Next state: set has priority over clear
    always_comb latch_d = (set_vec | (latch_q & ~clr_vec)) & LATCH_MASK;

    // Latched flag register
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= latch_d;
    end

    // Merge latched and live positions
    always_comb flag_vec = latch_q | (live_vec & LIVE_MASK);
endmodule

// File: rtl/xgi_irq_merge.sv
// Interrupt merge and read mux.
// Masks the flags with the enable register, gates the result with the master
// control value and selects read data by offset.
// Assumes enable and master values are already masked to implemented bits.
module xgi_irq_merge
    import xgi_pkg::*;
(
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] flag_vec,
    input  logic [DATA_W-1:0] en_q,
    input  logic [MCTL_W-1:0] mctl_q,
    output logic              pending,
    output logic              irq_req,
    output logic [DATA_W-1:0] rdata
);
    // Enabled flags and gated request
    always_comb begin
        pending = |(flag_vec & en_q);
        irq_req = pending && (mctl_q != '0);
    end

    // Read data by offset
    always_comb begin
        case (bus_addr)
            OFS_FLAG_CLRA: rdata = flag_vec;
            OFS_ENABLE:    rdata = en_q;
            OFS_MASTER:    rdata = DATA_W'(mctl_q);
            OFS_SUMMARY:   rdata = DATA_W'({irq_req, pending});
            default:       rdata = '0;
        endcase
    end
endmodule

// File: rtl/xfer_grp_irq_unit.sv
// Transfer group interrupt flag unit, top level.
// Collects the event inputs into a flag vector, decodes register writes and
// drives the interrupt request, line select and reset strobes.
// Assumes event inputs are synchronous one-cycle pulses, apart from the
// FIFO-not-empty level.
module xfer_grp_irq_unit
    import xgi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_fifo_nonempty,
    input  logic              ev_count_done,
    input  logic              ev_wait_timeout,
    input  logic              ev_ptc,
    input  logic              ev_stc,
    output logic              irq_req,
    output logic [1:0]        irq_line_sel,
    output logic              irq_open_drain,
    output logic              dma_rst_pulse,
    output logic              fifo_rst_pulse
);
    logic [DATA_W-1:0] set_vec, live_vec, clr_vec, flag_vec, en_q;
    logic [MCTL_W-1:0] mctl_q;
    logic              pending;

    // Place the event inputs at their flag positions
    always_comb begin
        set_vec          = '0;
        set_vec[FB_CNT]  = ev_count_done;
        set_vec[FB_WAIT] = ev_wait_timeout;
        set_vec[FB_PTC]  = ev_ptc;
        set_vec[FB_STC]  = ev_stc;
        live_vec           = '0;
        live_vec[FB_READY] = ev_fifo_nonempty;
    end

    xgi_reg_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .clr_vec    (clr_vec),
        .en_q       (en_q),
        .mctl_q     (mctl_q),
        .dma_rst_q  (dma_rst_pulse),
        .fifo_rst_q (fifo_rst_pulse)
    );

    xgi_flag_bank u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .live_vec (live_vec),
        .flag_vec (flag_vec)
    );

    xgi_irq_merge u_irq (
        .bus_addr (bus_addr),
        .flag_vec (flag_vec),
        .en_q     (en_q),
        .mctl_q   (mctl_q),
        .pending  (pending),
        .irq_req  (irq_req),
        .rdata    (bus_rdata)
    );

    // Drive selection outputs from master control
    always_comb begin
        irq_line_sel   = mctl_q[1:0];
        irq_open_drain = mctl_q[2];
    end
endmodule

// File: rtl/xgi_chk.sv
// Assertion checker for the transfer group interrupt flag unit.
// Relates event pulses, writes and outputs over time. Bound to the top module.
module xgi_chk
    import xgi_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              ev_wait_timeout,
    input logic              ev_ptc,
    input logic [DATA_W-1:0] flag_vec,
    input logic              irq_req,
    input logic [1:0]        irq_line_sel,
    input logic              irq_open_drain,
    input logic              dma_rst_pulse
);
    // R4
    ptc_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ptc |=> flag_vec[FB_PTC]);

    // R7
    wait_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wait_timeout |=> flag_vec[FB_WAIT]);

    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_vec[FB_CNT] && !(bus_wr && bus_addr == OFS_CLRB && bus_wdata[CB_CNT]))
        |=> flag_vec[FB_CNT]);

    // R8
    dma_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rst_pulse |-> $past(bus_wr && bus_addr == OFS_FLAG_CLRA && bus_wdata[CA_DMA]));

    // R11
    irq_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_line_sel == 2'b00 && !irq_open_drain) |-> !irq_req);

    // R11
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (flag_vec != '0));
endmodule

bind xfer_grp_irq_unit xgi_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_addr        (bus_addr),
    .bus_wr          (bus_wr),
    .bus_wdata       (bus_wdata),
    .ev_wait_timeout (ev_wait_timeout),
    .ev_ptc          (ev_ptc),
    .flag_vec        (flag_vec),
    .irq_req         (irq_req),
    .irq_line_sel    (irq_line_sel),
    .irq_open_drain  (irq_open_drain),
    .dma_rst_pulse   (dma_rst_pulse)
);

// File: tb/xfer_grp_irq_unit_bench.sv
module xfer_grp_irq_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ev_fifo_nonempty = 1'b0;
    logic       ev_count_done = 1'b0, ev_wait_timeout = 1'b0, ev_ptc = 1'b0, ev_stc = 1'b0;
    logic       irq_req, irq_open_drain, dma_rst_pulse, fifo_rst_pulse;
    logic [1:0] irq_line_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xfer_grp_irq_unit u_xfer_grp_irq_unit (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_fifo_nonempty(ev_fifo_nonempty), .ev_count_done(ev_count_done),
        .ev_wait_timeout(ev_wait_timeout), .ev_ptc(ev_ptc), .ev_stc(ev_stc),
        .irq_req(irq_req), .irq_line_sel(irq_line_sel),
        .irq_open_drain(irq_open_drain), .dma_rst_pulse(dma_rst_pulse),
        .fifo_rst_pulse(fifo_rst_pulse)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write one register; returns at the falling edge after the write edge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    // Read one register combinationally
    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // One-cycle event pulse: 1 count, 5 wait, 6 ptc, 7 stc
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            1: ev_count_done = 1'b1;
            5: ev_wait_timeout = 1'b1;
            6: ev_ptc = 1'b1;
            default: ev_stc = 1'b1;
        endcase
        @(negedge clk);
        ev_count_done = 0; ev_wait_timeout = 0; ev_ptc = 0; ev_stc = 0;
    endtask

    task automatic clear_all();
        wr(3'd0, 8'h38);
        wr(3'd1, 8'h01);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(3'd0, d); chk("R1 flags", d, 8'h00);
        rd(3'd2, d); chk("R1 enable", d, 8'h00);
        rd(3'd3, d); chk("R1 master", d, 8'h00);
        chk("R1 irq", {7'b0, irq_req}, 8'h00);
        chk("R1 strobes", {6'b0, dma_rst_pulse, fifo_rst_pulse}, 8'h00);
    endtask

    task automatic t_layout();
        logic [7:0] d;
        pulse(1); pulse(5); pulse(6); pulse(7);
        rd(3'd0, d); chk("R2 R4 latched layout", d, 8'hE2);
        repeat (3) @(negedge clk);
        rd(3'd0, d); chk("R4 flags hold", d, 8'hE2);
        clear_all();
    endtask

    task automatic t_live();
        logic [7:0] d;
        @(negedge clk); ev_fifo_nonempty = 1'b1;
        rd(3'd0, d); chk("R3 ready follows", d, 8'h01);
        wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
        rd(3'd0, d); chk("R3 ready no clear", d, 8'h01);
        ev_fifo_nonempty = 1'b0;
        rd(3'd0, d); chk("R3 ready drops", d, 8'h00);
    endtask

    task automatic t_clear_a();
        logic [7:0] d;
        pulse(1); pulse(5); pulse(6); pulse(7);
        wr(3'd0, 8'h07);
        rd(3'd0, d); chk("R5 low bits no effect", d, 8'hE2);
        wr(3'd0, 8'h10);
        rd(3'd0, d); chk("R5 clear ptc", d, 8'hA2);
        wr(3'd0, 8'h28);
        rd(3'd0, d); chk("R5 clear wait stc keeps cnt", d, 8'h02);
        wr(3'd1, 8'hFE);
        rd(3'd0, d); chk("R6 other bits no effect", d, 8'h02);
        wr(3'd1, 8'h01);
        rd(3'd0, d); chk("R6 clear cnt", d, 8'h00);
        rd(3'd1, d); chk("R6 reads zero", d, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        pulse(6);
        @(negedge clk);
        ev_ptc = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h10; bus_wr = 1'b1;
        @(negedge clk);
        ev_ptc = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        rd(3'd0, d); chk("R7 set wins", d, 8'h40);
        wr(3'd0, 8'h10);
        rd(3'd0, d); chk("R7 later clear", d, 8'h00);
    endtask

    task automatic t_strobes();
        logic [7:0] d;
        wr(3'd0, 8'h40);
        chk("R8 dma strobe", {6'b0, dma_rst_pulse, fifo_rst_pulse}, 8'h02);
        @(negedge clk);
        chk("R8 dma one cycle", {6'b0, dma_rst_pulse, fifo_rst_pulse}, 8'h00);
        pulse(1); pulse(5); pulse(6); pulse(7);
        wr(3'd0, 8'hF8);
        chk("R8 both strobes", {6'b0, dma_rst_pulse, fifo_rst_pulse}, 8'h03);
        rd(3'd0, d); chk("R8 F8 clears", d, 8'h02);
        @(negedge clk);
        chk("R8 strobes fall", {6'b0, dma_rst_pulse, fifo_rst_pulse}, 8'h00);
        wr(3'd1, 8'h01);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(3'd2, 8'hFF);
        rd(3'd2, d); chk("R9 enable mask", d, 8'hE3);
        wr(3'd3, 8'hFE);
        rd(3'd3, d); chk("R10 master readback", d, 8'h06);
        chk("R10 pins", {5'b0, irq_open_drain, irq_line_sel}, 8'h06);
        wr(3'd5, 8'hFF);
        rd(3'd5, d); chk("R12 unused addr", d, 8'h00);
        rd(3'd2, d); chk("R12 unused write ignored", d, 8'hE3);
        wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        wr(3'd3, 8'h01);
        pulse(6);
        chk("R11 disabled flag", {7'b0, irq_req}, 8'h00);
        rd(3'd4, d); chk("R12 no pending", d, 8'h00);
        wr(3'd2, 8'h40);
        chk("R11 irq raised", {7'b0, irq_req}, 8'h01);
        rd(3'd4, d); chk("R12 pending and irq", d, 8'h03);
        wr(3'd3, 8'h00);
        chk("R11 master off", {7'b0, irq_req}, 8'h00);
        rd(3'd4, d); chk("R12 pending only", d, 8'h01);
        wr(3'd3, 8'h04);
        chk("R11 open drain nonzero", {7'b0, irq_req}, 8'h01);
        wr(3'd0, 8'h10);
        chk("R11 irq drops on clear", {7'b0, irq_req}, 8'h00);
        wr(3'd2, 8'h01);
        @(negedge clk); ev_fifo_nonempty = 1'b1; #1;
        chk("R11 live ready irq", {7'b0, irq_req}, 8'h01);
        ev_fifo_nonempty = 1'b0;
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_layout();
        t_live();
        t_clear_a();
        t_collide();
        t_strobes();
        t_regs();
        t_irq();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule